// File: doc/BRIEF.md
# Banked Data Memory Access Unit

This unit sits between the instruction side and the data RAM of a small 8-bit microcontroller. Each cycle it takes an address, read and write strobes, and write data. It decides what that address means and resolves it to a physical RAM index. The unit holds four registers that appear in the address map:

- two 8-bit memory pointers,
- a bank selector,
- the accumulator.

Two addresses have no storage of their own. An access to the first goes to the location held in the first pointer. An access to the second goes to the location held in the second pointer.

The lower part of general RAM is common to every bank. The upper part is duplicated once per bank, and the bank selector picks which copy is used. Addresses between the mapped registers and the start of RAM stand for special-function registers that live elsewhere. Here they read as zero and ignore writes.

A read is synchronous: the value appears on `rd_data` one clock after the strobe and stays there until the next read. The resolved physical index and a RAM-hit flag are combinational from the current address and the pointer state.

Top module: `bank_dmem_unit`

## Requirements
- R1: After reset, the pointers, the bank selector, the accumulator, every RAM word and `rd_data` are all 00H.
- R2: First pointer (01H), second pointer (03H) and accumulator (05H) are read and written as ordinary 8-bit registers; a write takes effect at the rising edge.
- R3: An access to 00H uses the first pointer's value as the effective address, and an access to 02H uses the second pointer's value. The target may be any mapped register or RAM location.
- R4: If an access to 00H or 02H yields an effective address of 00H or 02H, a read returns 00H, a write changes nothing, `ram_hit` is 0 and `phys_addr` is 0.
- R5: A write to the bank selector (04H) keeps only bit 0; reading 04H returns that bit with bits 7..1 as 0.
- R6: Effective addresses 20H..3FH reach the same RAM word whatever the bank selector holds, with `phys_addr` = address − 20H.
- R7: Effective addresses 40H..FFH are banked, with `phys_addr` = 32 + bank×192 + (address − 40H). A write in one bank leaves the other bank's word at the same address untouched.
- R8: Effective addresses 06H..1FH read as 00H, ignore writes, and give `ram_hit` = 0 and `phys_addr` = 0.
- R9: `rd_data` updates one cycle after a read strobe and holds while no read is strobed. A read and a write to the same location in one cycle return the old value.
- R10: `ram_hit` is 1 exactly when the effective access lands in RAM (effective address ≥ 20H and not neutralised), and `phys_addr` is then below 416.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Instruction-side data address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| phys_addr | output | 9 | Resolved physical RAM index, 0 when not a RAM access |
| ram_hit | output | 1 | Current access targets RAM |

## Verification
The bench builds the unit with its default parameters: 8-bit addresses and data, two banks, RAM starting at 20H and banking starting at 40H. These values make both bank copies of 40H reachable, along with the shared word at 30H and the RAM boundary at 20H. They also let the pointers aim at the indirect slots, at another pointer, at the accumulator and at the unimplemented special-function gap. The test drives bank-selector values with upper bits set, and it performs a read and a write on the same cycle.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   // What an effective address resolves to.
   typedef enum logic [2:0] {
      TGT_PTR0,
      TGT_PTR1,
      TGT_BANK,
      TGT_ACC,
      TGT_RAM,
      TGT_VOID,
      TGT_NULL
   } tgt_e;

   function automatic int ceil_log2(input int n);
      int r;
      r = 0;
      while ((1 << r) < n) r++;
      return r;
   endfunction

endpackage

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
   import dmem_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_BANKS = 2,
   parameter int BANK_BITS = 1,
   parameter int PHYS_W = 9,
   parameter int SHARED_N = 32,
   parameter int BANK_N = 192,
   parameter logic [ADDR_W-1:0] IND0_ADDR = 'h00,
   parameter logic [ADDR_W-1:0] IND1_ADDR = 'h02,
   parameter logic [ADDR_W-1:0] PTR0_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] PTR1_ADDR = 'h03,
   parameter logic [ADDR_W-1:0] BANK_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] ACC_ADDR = 'h05,
   parameter logic [ADDR_W-1:0] RAM_BASE = 'h20,
   parameter logic [ADDR_W-1:0] BANK_BASE = 'h40
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [ADDR_W-1:0]    ptr0,
   input  logic [ADDR_W-1:0]    ptr1,
   input  logic [BANK_BITS-1:0] bank,
   output logic [ADDR_W-1:0]    eff_addr,
   output tgt_e                 tgt,
   output logic [PHYS_W-1:0]    phys_idx
);

   logic via_ptr;
   logic lands_on_ind;
   logic [PHYS_W-1:0] shared_off;
   logic [PHYS_W-1:0] banked_off;

   always_comb begin
      via_ptr = (addr == IND0_ADDR) || (addr == IND1_ADDR);
      if (addr == IND0_ADDR)      eff_addr = ptr0;
      else if (addr == IND1_ADDR) eff_addr = ptr1;
      else                        eff_addr = addr;
      lands_on_ind = (eff_addr == IND0_ADDR) || (eff_addr == IND1_ADDR);
   end

   always_comb begin
      if (via_ptr && lands_on_ind)      tgt = TGT_NULL;
      else if (eff_addr == PTR0_ADDR)   tgt = TGT_PTR0;
      else if (eff_addr == PTR1_ADDR)   tgt = TGT_PTR1;
      else if (eff_addr == BANK_ADDR)   tgt = TGT_BANK;
      else if (eff_addr == ACC_ADDR)    tgt = TGT_ACC;
      else if (eff_addr >= RAM_BASE)    tgt = TGT_RAM;
      else                              tgt = TGT_VOID;
   end

   // Shared window index, and banked window index (bank-scaled offset).
   assign shared_off = PHYS_W'(eff_addr - RAM_BASE);

   generate
      if (NUM_BANKS == 1) begin : g_single
         assign banked_off = PHYS_W'(SHARED_N) + PHYS_W'(eff_addr - BANK_BASE);
      end else begin : g_multi
         assign banked_off = PHYS_W'(SHARED_N)
                           + PHYS_W'(bank) * PHYS_W'(BANK_N)
                           + PHYS_W'(eff_addr - BANK_BASE);
      end
   endgenerate

   always_comb begin
      if (tgt != TGT_RAM)            phys_idx = '0;
      else if (eff_addr < BANK_BASE) phys_idx = shared_off;
      else                           phys_idx = banked_off;
   end

endmodule

// File: rtl/dmem_core_regs.sv
module dmem_core_regs
   import dmem_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int BANK_BITS = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  tgt_e                 tgt,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [ADDR_W-1:0]    ptr0,
   output logic [ADDR_W-1:0]    ptr1,
   output logic [BANK_BITS-1:0] bank,
   output logic [DATA_W-1:0]    acc,
   output logic [DATA_W-1:0]    rd_val
);

   logic we_p0, we_p1, we_bk, we_acc;

   assign we_p0  = wr_en && (tgt == TGT_PTR0);
   assign we_p1  = wr_en && (tgt == TGT_PTR1);
   assign we_bk  = wr_en && (tgt == TGT_BANK);
   assign we_acc = wr_en && (tgt == TGT_ACC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr0 <= '0;
         ptr1 <= '0;
         bank <= '0;
         acc  <= '0;
      end else begin
         if (we_p0)  ptr0 <= wr_data[ADDR_W-1:0];
         if (we_p1)  ptr1 <= wr_data[ADDR_W-1:0];
         if (we_bk)  bank <= wr_data[BANK_BITS-1:0];
         if (we_acc) acc  <= wr_data;
      end
   end

   // Register read mux; bank selector zero-extended.
   always_comb begin
      case (tgt)
         TGT_PTR0: rd_val = DATA_W'(ptr0);
         TGT_PTR1: rd_val = DATA_W'(ptr1);
         TGT_BANK: rd_val = DATA_W'(bank);
         TGT_ACC:  rd_val = acc;
         default:  rd_val = '0;
      endcase
   end

   p_bank_keeps_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we_bk |=> bank == $past(wr_data[BANK_BITS-1:0]));

   p_ptr0_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_p0 |=> $stable(ptr0));

   p_acc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_acc |=> acc == $past(wr_data));

endmodule

// File: rtl/dmem_bank_ram.sv
module dmem_bank_ram #(
   parameter int DATA_W = 8,
   parameter int DEPTH = 416,
   parameter int IDX_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] rd
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wd;
      end
   end

   assign rd = (int'(idx) < DEPTH) ? mem[idx] : '0;

   p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(idx)] == $past(wd));

endmodule

// File: rtl/bank_dmem_unit.sv
module bank_dmem_unit
   import dmem_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int NUM_BANKS = 2,
   parameter logic [ADDR_W-1:0] IND0_ADDR = 'h00,
   parameter logic [ADDR_W-1:0] IND1_ADDR = 'h02,
   parameter logic [ADDR_W-1:0] PTR0_ADDR = 'h01,
   parameter logic [ADDR_W-1:0] PTR1_ADDR = 'h03,
   parameter logic [ADDR_W-1:0] BANK_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] ACC_ADDR = 'h05,
   parameter logic [ADDR_W-1:0] RAM_BASE = 'h20,
   parameter logic [ADDR_W-1:0] BANK_BASE = 'h40,
   localparam int SHARED_N = int'(BANK_BASE) - int'(RAM_BASE),
   localparam int BANK_N = (1 << ADDR_W) - int'(BANK_BASE),
   localparam int RAM_N = SHARED_N + NUM_BANKS * BANK_N,
   localparam int PHYS_W = dmem_pkg::ceil_log2(RAM_N),
   localparam int BANK_BITS = (NUM_BANKS > 1) ? dmem_pkg::ceil_log2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [PHYS_W-1:0] phys_addr,
   output logic              ram_hit
);

   generate
      if (NUM_BANKS < 1 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_chk_banks
         $error("NUM_BANKS must be a power of two");
      end
      if (DATA_W < ADDR_W) begin : g_chk_width
         $error("DATA_W must cover a pointer");
      end
      if (RAM_BASE >= BANK_BASE || ACC_ADDR >= RAM_BASE || BANK_ADDR >= RAM_BASE
          || PTR0_ADDR >= RAM_BASE || PTR1_ADDR >= RAM_BASE) begin : g_chk_map
         $error("registers must sit below shared RAM, shared RAM below banked RAM");
      end
   endgenerate

   logic [ADDR_W-1:0]    ptr0, ptr1, eff_addr;
   logic [BANK_BITS-1:0] bank;
   logic [DATA_W-1:0]    acc, reg_rd, ram_rd, rd_next, rd_q;
   logic [PHYS_W-1:0]    phys_idx;
   tgt_e                 tgt;

   dmem_addr_resolve #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS),
      .PHYS_W(PHYS_W), .SHARED_N(SHARED_N), .BANK_N(BANK_N),
      .IND0_ADDR(IND0_ADDR), .IND1_ADDR(IND1_ADDR),
      .PTR0_ADDR(PTR0_ADDR), .PTR1_ADDR(PTR1_ADDR),
      .BANK_ADDR(BANK_ADDR), .ACC_ADDR(ACC_ADDR),
      .RAM_BASE(RAM_BASE), .BANK_BASE(BANK_BASE)
   ) u_resolve (
      .addr(addr), .ptr0(ptr0), .ptr1(ptr1), .bank(bank),
      .eff_addr(eff_addr), .tgt(tgt), .phys_idx(phys_idx)
   );

   dmem_core_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_BITS(BANK_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tgt(tgt), .wr_data(wr_data),
      .ptr0(ptr0), .ptr1(ptr1), .bank(bank), .acc(acc), .rd_val(reg_rd)
   );

   dmem_bank_ram #(
      .DATA_W(DATA_W), .DEPTH(RAM_N), .IDX_W(PHYS_W)
   ) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_en && (tgt == TGT_RAM)),
      .idx(phys_idx), .wd(wr_data), .rd(ram_rd)
   );

   assign rd_next = (tgt == TGT_RAM) ? ram_rd : reg_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= rd_next;
   end

   assign rd_data   = rd_q;
   assign ram_hit   = (tgt == TGT_RAM);
   assign phys_addr = phys_idx;

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> rd_data == '0);

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   p_null_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && tgt == TGT_NULL) |=> rd_data == '0);

   p_null_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == TGT_NULL) |-> (!ram_hit && phys_addr == '0));

   p_void_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && tgt == TGT_VOID) |=> rd_data == '0);

   p_shared_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_hit && eff_addr < BANK_BASE) |-> int'(phys_addr) < SHARED_N);

   p_hit_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ram_hit |-> int'(phys_addr) < RAM_N);

endmodule

// File: tb/bank_dmem_unit_tb.sv
`timescale 1ns/1ps
module bank_dmem_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [8:0] phys_addr;
   logic       ram_hit;

   int n_checks = 0;
   int n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   bank_dmem_unit u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .phys_addr(phys_addr), .ram_hit(ram_hit)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: one access per cycle, reads push their expectation.
   task automatic op(input logic w, input logic r, input logic [7:0] a,
                     input logic [7:0] d, input logic [7:0] e, input string tag);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wr_data = d;
      if (r) begin
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      op(1'b1, 1'b0, a, d, 8'h00, "");
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      op(1'b0, 1'b1, a, 8'h00, e, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic probe(input logic [7:0] a, input int ep, input logic eh, input string tag);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; addr = a;
      #2;
      chk(phys_addr == 9'(ep), {tag, " phys_addr"}, int'(phys_addr), ep);
      chk(ram_hit == eh, {tag, " ram_hit"}, int'(ram_hit), int'(eh));
   endtask

   // Monitor: pops one expectation per read, after the capturing edge.
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && rd_en) begin
            #5;
            if (exp_q.size() == 0) begin
               chk(1'b0, "scoreboard underflow", int'(rd_data), 0);
            end else begin
               automatic logic [7:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               chk(rd_data == e, t, int'(rd_data), int'(e));
            end
         end
      end
   end

   initial begin
      #(20 * 200000);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
      rd(8'h01, 8'h00, "R1 ptr0 reset");
      rd(8'h40, 8'h00, "R1 ram reset");
      rd(8'h05, 8'h00, "R1 acc reset");

      wr(8'h05, 8'hA5);  rd(8'h05, 8'hA5, "R2 acc");
      wr(8'h01, 8'h30);  rd(8'h01, 8'h30, "R2 ptr0");
      wr(8'h03, 8'h41);  rd(8'h03, 8'h41, "R2 ptr1");

      wr(8'h30, 8'h5C);
      probe(8'h30, 16, 1'b1, "R6 bank0");
      wr(8'h04, 8'hFF);  rd(8'h04, 8'h01, "R5 only bit0 kept");
      rd(8'h30, 8'h5C, "R6 shared in bank1");
      probe(8'h30, 16, 1'b1, "R6 bank1");

      wr(8'h40, 8'h77);
      probe(8'h40, 224, 1'b1, "R7 bank1 index");
      wr(8'h04, 8'h00);  rd(8'h40, 8'h00, "R7 bank0 untouched");
      probe(8'h40, 32, 1'b1, "R7 bank0 index");
      wr(8'h40, 8'h11);
      wr(8'h04, 8'h01);  rd(8'h40, 8'h77, "R7 bank1 kept");
      wr(8'h04, 8'h02);  rd(8'h40, 8'h11, "R5 upper bits ignored");
      rd(8'h04, 8'h00, "R5 readback");

      rd(8'h00, 8'h5C, "R3 read via ptr0");
      probe(8'h00, 16, 1'b1, "R3 ptr0 resolve");
      wr(8'h00, 8'h99);  rd(8'h30, 8'h99, "R3 write via ptr0");
      rd(8'h02, 8'h00, "R3 read via ptr1");
      wr(8'h02, 8'h66);
      probe(8'h41, 33, 1'b1, "R7 0x41 index");
      rd(8'h41, 8'h66, "R3 write via ptr1");
      wr(8'h03, 8'h05);  rd(8'h02, 8'hA5, "R3 ptr1 to acc");

      wr(8'h01, 8'h02);  rd(8'h00, 8'h00, "R4 read neutralised");
      wr(8'h00, 8'hEE);
      probe(8'h00, 0, 1'b0, "R4 no hit");
      rd(8'h01, 8'h02, "R4 ptr0 unchanged");
      wr(8'h03, 8'h00);  wr(8'h02, 8'h55);
      rd(8'h03, 8'h00, "R4 ptr1 unchanged");
      rd(8'h05, 8'hA5, "R4 acc unchanged");
      rd(8'h30, 8'h99, "R4 ram unchanged");
      rd(8'h02, 8'h00, "R4 read via ptr1 neutralised");

      wr(8'h03, 8'h01);  wr(8'h02, 8'h30);
      rd(8'h01, 8'h30, "R3 ptr1 writes ptr0");

      wr(8'h0A, 8'h3C);  rd(8'h0A, 8'h00, "R8 gap reads zero");
      probe(8'h0A, 0, 1'b0, "R8 gap");
      probe(8'h1F, 0, 1'b0, "R8 gap top");
      probe(8'h20, 0, 1'b1, "R10 ram bottom");
      probe(8'hFF, 223, 1'b1, "R10 bank0 top");

      op(1'b1, 1'b1, 8'h30, 8'h42, 8'h99, "R9 read-before-write");
      rd(8'h30, 8'h42, "R9 new value");
      idle();
      wr(8'h05, 8'h13);
      idle(); idle();
      chk(rd_data == 8'h42, "R9 hold", int'(rd_data), 8'h42);

      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(8'h05, 8'h00, "R1 acc after reset");
      rd(8'h40, 8'h00, "R1 ram after reset");
      rd(8'h01, 8'h00, "R1 ptr0 after reset");
      idle(); idle();
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule